// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two 16-bit two's complement operands and returns the full 32-bit signed product. The multiplier operand is recoded two bits at a time into signed radix-4 digits, which halves the number of partial products compared with a bit-by-bit array. Each partial product is sign-extended to the full product width and the rows are compressed with carry-save adders. A carry-lookahead adder then resolves the last two vectors into the product.

The datapath is purely combinational. A parameter selects whether the result leaves through an output register, which is the default, or straight from the adder. With the register present, a product is captured only on cycles that carry a valid operand pair. The product then holds until the next valid pair arrives. Accumulation and saturation belong to the surrounding unit and are not part of this block.

Top module: `booth_mul`

## Requirements
- R1: For every operand pair presented with `in_valid` high, `product` equals the exact signed product of `mcand` and `mplr` as a 32-bit two's complement value.
- R2: With the default output register, `out_valid` is high exactly one clock after a cycle with `in_valid` high, and low one clock after a cycle with `in_valid` low. The matching product appears in the same cycle as `out_valid`.
- R3: Radix-4 recoding is correct for every digit value. Digit i is taken from the multiplier bits (2i+1, 2i, 2i-1), with bit -1 read as 0. The triplets 000 and 111 give digit 0, 001 and 010 give +1, 011 gives +2, 100 gives -2, and 101 and 110 give -1. Multipliers 0x5555, 0xAAAA, 0x3333, 0xCCCC, 0x6666 and 0x9999 all give exact products.
- R4: A negative multiplicand with a positive multiplier gives the exact negative product. This holds only if every partial product is sign-extended to 32 bits.
- R5: A negative multiplier gives the exact product, with its top bit weighted as -32768.
- R6: A zero operand on either side gives product 0. Multiplier 0xFFFF gives the negated multiplicand.
- R7: -32768 times -32768 gives 0x40000000. -32768 times 32767 gives 0xC0008000.
- R8: While and directly after a synchronous reset, `out_valid` is 0 and `product` is 0.
- R9: On cycles with `in_valid` low, the registered `product` keeps its previous value.
- R10: Sums whose carries cross every 4-bit lookahead group resolve exactly. Examples are 32767 times 32767 giving 0x3FFF0001 and 1 times -1 giving 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair on `mcand`/`mplr` is valid this cycle |
| mcand | input | 16 | Multiplicand, two's complement |
| mplr | input | 16 | Multiplier, two's complement, Booth-recoded |
| out_valid | output | 1 | `product` holds a new result this cycle |
| product | output | 32 | Signed product |

## Verification
The bench drives multipliers built from repeating bit patterns so that every triplet code lands in some digit position. It pairs these with negative multiplicands, so a wrong digit table or a missing sign extension shows up as a product off by a shifted multiple of the multiplicand. It also drives the most negative operand against itself and against the largest positive value. A design that lost the top carry of the negated double multiplicand would return a negative or zero product for these pairs. Products whose carries ripple through all eight lookahead groups, such as 1 times -1, catch a broken group carry. Idle gaps between operands check that the output register does not capture when no valid pair is present.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // One signed radix-4 digit: magnitude select and sign
  typedef struct packed {
    logic neg;  // subtract the selected magnitude
    logic one;  // magnitude is the multiplicand
    logic two;  // magnitude is twice the multiplicand
  } booth_digit_t;

  // Map a multiplier triplet {hi, mid, lo} to a digit
  function automatic booth_digit_t booth_encode(input logic [2:0] trip);
    booth_digit_t d;
    d.one = trip[1] ^ trip[0];
    d.two = (trip == 3'b011) || (trip == 3'b100);
    d.neg = trip[2] & ~(trip[1] & trip[0]);
    return d;
  endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]                 mplr,
  output booth_digit_t [W/2-1:0]       digits
);
  localparam int NDIG = W / 2;

  // Multiplier extended with an implicit zero below bit 0
  logic [W:0] ext;
  assign ext = {mplr, 1'b0};

  for (genvar i = 0; i < NDIG; i++) begin : g_dig
    assign digits[i] = booth_encode(ext[2*i+2 -: 3]);
  end

endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
  import booth_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]                  mcand,
  input  booth_digit_t [W/2-1:0]        digits,
  output logic [W/2:0][2*W-1:0]         rows
);
  localparam int NDIG = W / 2;
  localparam int PW   = 2 * W;

  for (genvar i = 0; i < NDIG; i++) begin : g_row
    logic [W:0]    mag;
    logic [W:0]    sel;
    logic [PW-1:0] ext;

    always_comb begin
      if (digits[i].one)      mag = {mcand[W-1], mcand};
      else if (digits[i].two) mag = {mcand, 1'b0};
      else                    mag = '0;
      // One's complement here; the +1 goes into the correction row
      sel = digits[i].neg ? ~mag : mag;
      ext = {{(PW-W-1){sel[W]}}, sel};
    end

    assign rows[i] = ext << (2 * i);
  end

  // Correction row: +1 at the weight of each negated row
  always_comb begin
    rows[NDIG] = '0;
    for (int i = 0; i < NDIG; i++) begin
      rows[NDIG][2*i] = digits[i].neg;
    end
  end

endmodule

// File: rtl/booth_csa_chain.sv
module booth_csa_chain #(
  parameter int PW   = 32,
  parameter int ROWS = 9
) (
  input  logic [ROWS-1:0][PW-1:0] rows,
  output logic [PW-1:0]           sum_vec,
  output logic [PW-1:0]           carry_vec
);
  logic [PW-1:0] ps [1:ROWS-1];
  logic [PW-1:0] pc [1:ROWS-1];

  assign ps[1] = rows[0];
  assign pc[1] = rows[1];

  for (genvar k = 2; k < ROWS; k++) begin : g_csa
    assign ps[k] = ps[k-1] ^ pc[k-1] ^ rows[k];
    assign pc[k] = {(ps[k-1][PW-2:0] & pc[k-1][PW-2:0]) |
                    (ps[k-1][PW-2:0] & rows[k][PW-2:0]) |
                    (pc[k-1][PW-2:0] & rows[k][PW-2:0]), 1'b0};
  end

  assign sum_vec   = ps[ROWS-1];
  assign carry_vec = pc[ROWS-1];

endmodule

// File: rtl/booth_cla.sv
module booth_cla #(
  parameter int PW = 32
) (
  input  logic [PW-1:0] x,
  input  logic [PW-1:0] y,
  output logic [PW-1:0] sum
);
  localparam int NG = PW / 4;

  logic [PW-1:0] g, p, c;
  logic [NG:0]   gc;

  assign g     = x & y;
  assign p     = x ^ y;
  assign gc[0] = 1'b0;

  for (genvar k = 0; k < NG; k++) begin : g_grp
    localparam int B = 4 * k;
    logic grp_g, grp_p;

    // Carries inside the group, fully expanded
    assign c[B]   = gc[k];
    assign c[B+1] = g[B] | (p[B] & gc[k]);
    assign c[B+2] = g[B+1] | (p[B+1] & g[B]) | (p[B+1] & p[B] & gc[k]);
    assign c[B+3] = g[B+2] | (p[B+2] & g[B+1]) | (p[B+2] & p[B+1] & g[B]) |
                    (p[B+2] & p[B+1] & p[B] & gc[k]);

    // Group generate and propagate
    assign grp_g = g[B+3] | (p[B+3] & g[B+2]) | (p[B+3] & p[B+2] & g[B+1]) |
                   (p[B+3] & p[B+2] & p[B+1] & g[B]);
    assign grp_p = &p[B+3:B];
    assign gc[k+1] = grp_g | (grp_p & gc[k]);
  end

  assign sum = p ^ c;

  always_comb begin
    AST_CLA_SUM: assert ({gc[NG], sum} == {1'b0, x} + {1'b0, y}); // R10
  end

endmodule

// File: rtl/booth_mul.sv
module booth_mul
  import booth_pkg::*;
#(
  parameter int W       = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [W-1:0]     mcand,
  input  logic [W-1:0]     mplr,
  output logic             out_valid,
  output logic [2*W-1:0]   product
);
  localparam int NDIG = W / 2;
  localparam int ROWS = NDIG + 1;
  localparam int PW   = 2 * W;

  booth_digit_t [NDIG-1:0]     digits;
  logic [ROWS-1:0][PW-1:0]     rows;
  logic [PW-1:0]               sv, cv, comb_prod;

  booth_recoder #(.W(W)) u_rec (
    .mplr   (mplr),
    .digits (digits)
  );

  booth_pp_gen #(.W(W)) u_pp (
    .mcand  (mcand),
    .digits (digits),
    .rows   (rows)
  );

  booth_csa_chain #(.PW(PW), .ROWS(ROWS)) u_csa (
    .rows      (rows),
    .sum_vec   (sv),
    .carry_vec (cv)
  );

  booth_cla #(.PW(PW)) u_cla (
    .x   (sv),
    .y   (cv),
    .sum (comb_prod)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        product   <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) product <= comb_prod;
      end
    end

    // Behavioural reference for the checks below
    logic signed [PW-1:0] ref_full;
    always_comb ref_full = PW'($signed(mcand)) * PW'($signed(mplr));

    localparam logic [W-1:0]  MINV = {1'b1, {(W-1){1'b0}}};
    localparam logic [PW-1:0] MINSQ = {2'b01, {(PW-2){1'b0}}};

    AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> product == $past(ref_full)); // R1
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R2
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid); // R2
    AST_MIN_SQUARE: assert property (@(posedge clk) disable iff (rst)
      (in_valid && mcand == MINV && mplr == MINV) |=> product == MINSQ); // R7
    AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(product)); // R9
  end else begin : g_comb
    assign out_valid = in_valid;
    assign product   = comb_prod;
  end

endmodule

// File: tb/booth_mul_bench.sv
module booth_mul_bench;
  localparam int W = 16;
  localparam int PW = 2 * W;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 50000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [W-1:0]  mcand = '0;
  logic [W-1:0]  mplr = '0;
  logic          out_valid;
  logic [PW-1:0] product;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [PW-1:0] exp_q [$];
  string         tag_q [$];
  logic [PW-1:0] last_prod = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  booth_mul #(.W(W), .OUT_REG(1'b1)) u_booth_mul (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .mcand     (mcand),
    .mplr      (mplr),
    .out_valid (out_valid),
    .product   (product)
  );

  function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [PW-1:0] sa, sb;
    sa = PW'($signed(a));
    sb = PW'($signed(b));
    return sa * sb;
  endfunction

  task automatic check(input string tag, input logic [PW-1:0] got, input logic [PW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Driver: one operand pair per call, expected value into the scoreboard
  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [PW-1:0] exp, input string tag);
    @(negedge clk);
    mcand = a;
    mplr = b;
    in_valid = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      mcand = mcand ^ 16'h5A5A;
      mplr = mplr + 16'h1357;
    end
  endtask

  // Monitor: pops the scoreboard on every valid output
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst) begin
        last_prod = product;
      end else if (out_valid) begin
        if (exp_q.size() == 0) begin
          check("R2 unexpected out_valid", {PW{1'b1}}, '0);
        end else begin
          check(tag_q.pop_front(), product, exp_q.pop_front());
        end
        last_prod = product;
      end else begin
        check("R9 hold", product, last_prod);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    check("R8 reset out_valid", PW'(out_valid), '0);
    check("R8 reset product", product, '0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R8 after reset out_valid", PW'(out_valid), '0);
    check("R8 after reset product", product, '0);

    // R1 basic small values
    send(16'd3, 16'd5, ref_mul(16'd3, 16'd5), "R1 3x5");
    send(16'd1234, 16'd567, ref_mul(16'd1234, 16'd567), "R1 1234x567");
    // R3 every triplet code
    send(16'h1234, 16'h5555, ref_mul(16'h1234, 16'h5555), "R3 x5555");
    send(16'h1234, 16'hAAAA, ref_mul(16'h1234, 16'hAAAA), "R3 xAAAA");
    send(16'hF00D, 16'h3333, ref_mul(16'hF00D, 16'h3333), "R3 x3333");
    send(16'hF00D, 16'hCCCC, ref_mul(16'hF00D, 16'hCCCC), "R3 xCCCC");
    send(16'h7A5B, 16'h6666, ref_mul(16'h7A5B, 16'h6666), "R3 x6666");
    send(16'h8421, 16'h9999, ref_mul(16'h8421, 16'h9999), "R3 x9999");
    idle(3);
    // R4 negative multiplicand
    send(16'hFFFD, 16'd7, 32'hFFFF_FFEB, "R4 -3x7");
    send(16'h8001, 16'h1234, ref_mul(16'h8001, 16'h1234), "R4 neg mcand");
    // R5 negative multiplier
    send(16'd7, 16'hFFFD, 32'hFFFF_FFEB, "R5 7x-3");
    send(16'h0123, 16'h8000, ref_mul(16'h0123, 16'h8000), "R5 x-32768");
    send(16'hFF00, 16'hFF00, 32'h0001_0000, "R5 -256x-256");
    // R6 zeros and all ones
    send(16'h0000, 16'hBEEF, 32'h0, "R6 zero mcand");
    send(16'hBEEF, 16'h0000, 32'h0, "R6 zero mplr");
    send(16'h1234, 16'hFFFF, 32'hFFFF_EDCC, "R6 x-1");
    idle(2);
    // R7 extremes
    send(16'h8000, 16'h8000, 32'h4000_0000, "R7 min x min");
    send(16'h8000, 16'h7FFF, 32'hC000_8000, "R7 min x max");
    send(16'h7FFF, 16'h8000, 32'hC000_8000, "R7 max x min");
    // R10 long carries
    send(16'h7FFF, 16'h7FFF, 32'h3FFF_0001, "R10 max x max");
    send(16'h0001, 16'hFFFF, 32'hFFFF_FFFF, "R10 1x-1");
    send(16'hFFFF, 16'hFFFF, 32'h0000_0001, "R10 -1x-1");
    idle(4);

    // R1 pseudo-random pairs with occasional gaps
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] a, b;
      a = W'($urandom);
      b = W'($urandom);
      send(a, b, ref_mul(a, b), "R1 random");
      if (($urandom % 7) == 0) idle(1 + ($urandom % 3));
    end
    idle(4);
    check("R2 scoreboard drained", PW'(exp_q.size()), '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule